// File: doc/BRIEF.md
# Adaptive Redundancy Mode Controller

This block supervises three identical processing units that all see the same input stream. It decides which units are powered on, whether the pairwise mismatch detector or the external majority voter is active, and which of four sources drives the system output: unit 1, unit 2, unit 3 or the voted word. The voting logic is outside this block. The block receives the voted word and the voter's 3-bit report as inputs.

After reset the block runs two units side by side and keeps the third as a cold spare. As soon as the two online units disagree, it brings the spare online and switches the output to the voted word. A host can also force simplex, duplex or triple operation through a one-cycle command port. A forced mode holds until the host releases the block back to automatic control. A status byte reports the current mode, the last voter report, a sticky mismatch flag, a sticky repair request and the override state.

Top module: `redundancy_supervisor`

## Requirements
- R1: While reset is asserted and right after it is released, the block is in duplex mode: `unit_en`=3'b011, `det_en`=1, `vote_en`=0, `sel`=2'b00 and `status`=8'h01.
- R2: `mismatch` is 1 exactly when the mode is duplex and `unit1_out` differs from `unit2_out`. In simplex and triple mode it is 0 whatever the inputs are.
- R3: If `mismatch` is high at a clock edge, no host override is active and no command is presented, the next cycle is triple mode: `unit_en`=3'b111, `vote_en`=1, `det_en`=0, `sel`=2'b11.
- R4: In duplex mode `sys_out` equals `unit1_out`.
- R5: Command op 3'b001 with `cmd_unit` 0, 1 or 2 selects simplex mode on the next clock. Only unit `cmd_unit`+1 is enabled (`unit_en` bit k belongs to unit k+1), `det_en`=`vote_en`=0, and `sys_out` follows that unit.
- R6: `sel` encodes the output source as 00 for unit 1, 01 for unit 2, 10 for unit 3 and 11 for the voted word, and `sys_out` always follows `sel`.
- R7: In triple mode `status[4:2]` takes the value of `voter_rpt` at every clock edge. In the other modes it keeps its last value.
- R8: `status[6]` (repair request) is set when `voter_rpt`=3'b111 is seen at a clock edge in triple mode. It stays set until a clear command (op 3'b101) arrives, and the clear wins if both happen at the same edge.
- R9: Mode commands (op 3'b001 simplex, 3'b010 duplex, 3'b011 triple) take effect on the next clock and set `status[7]` (override). While override is set, a mismatch does not cause promotion. Op 3'b100 clears override and leaves the mode as it is.
- R10: A simplex command with `cmd_unit`=3 has no effect on mode, enables, selection or override.
- R11: `status` = {override, repair, mismatch flag, latched voter report[2:0], mode[1:0]}. Mode is 00 simplex, 01 duplex, 10 triple. The mismatch flag is set whenever `mismatch` is high at an edge and is cleared by op 3'b101.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| unit1_out | input | W | Output word of unit 1 |
| unit2_out | input | W | Output word of unit 2 |
| unit3_out | input | W | Output word of unit 3 |
| voted_word | input | W | Majority word from the external voter |
| voter_rpt | input | 3 | Voter report (111 = all disagree) |
| cmd_valid | input | 1 | Host command strobe, one cycle |
| cmd_op | input | 3 | Host command code |
| cmd_unit | input | 2 | Unit index for a simplex command |
| unit_en | output | 3 | Per-unit enables, bit k for unit k+1 |
| det_en | output | 1 | Mismatch detector enable |
| vote_en | output | 1 | Voter enable |
| sel | output | 2 | Output selector lines |
| sys_out | output | W | Selected system output |
| mismatch | output | 1 | Detector flag for the current cycle |
| status | output | 8 | Fault status byte |

## Verification
The stimulus holds unit 2 at a value off by one bit from unit 1, acting as a stuck bit. This separates clean duplex running from automatic promotion, and the same pattern is repeated under host override to show that promotion is suppressed. In triple mode the voter report is stepped through 010, 111 and 000. This separates latching from holding and shows the sticky repair bit surviving a clean report until it is cleared. Simplex commands for each legal unit index and for the illegal index 3 give each unit a distinct value, so a wrong select code or a wrong enable pattern shows up in `sys_out` and `unit_en`.

// File: rtl/redundancy_supervisor.sv
module redundancy_supervisor #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] unit1_out,
  input  logic [W-1:0] unit2_out,
  input  logic [W-1:0] unit3_out,
  input  logic [W-1:0] voted_word,
  input  logic [2:0]   voter_rpt,
  input  logic         cmd_valid,
  input  logic [2:0]   cmd_op,
  input  logic [1:0]   cmd_unit,
  output logic [2:0]   unit_en,
  output logic         det_en,
  output logic         vote_en,
  output logic [1:0]   sel,
  output logic [W-1:0] sys_out,
  output logic         mismatch,
  output logic [7:0]   status
);
  localparam logic [1:0] M_SIM = 2'b00;
  localparam logic [1:0] M_DUP = 2'b01;
  localparam logic [1:0] M_TRI = 2'b10;

  logic [1:0] mode_q, pick_q;
  logic       ovr_q, rep_q, mm_q;
  logic [2:0] rpt_q;

  wire do_sim = cmd_valid && cmd_op == 3'b001 && cmd_unit != 2'b11;
  wire do_dup = cmd_valid && cmd_op == 3'b010;
  wire do_tri = cmd_valid && cmd_op == 3'b011;
  wire do_rel = cmd_valid && cmd_op == 3'b100;
  wire do_clr = cmd_valid && cmd_op == 3'b101;

  assign det_en   = mode_q == M_DUP;
  assign vote_en  = mode_q == M_TRI;
  assign mismatch = det_en && (unit1_out != unit2_out);
  assign unit_en  = (mode_q == M_SIM) ? (3'b001 << pick_q) : (det_en ? 3'b011 : 3'b111);
  assign sel      = (mode_q == M_SIM) ? pick_q : (det_en ? 2'b00 : 2'b11);
  assign status   = {ovr_q, rep_q, mm_q, rpt_q, mode_q};

  always_comb begin
    case (sel)
      2'b00:   sys_out = unit1_out;
      2'b01:   sys_out = unit2_out;
      2'b10:   sys_out = unit3_out;
      default: sys_out = voted_word;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_DUP;
      pick_q <= 2'b00;
      ovr_q  <= 1'b0;
      rep_q  <= 1'b0;
      mm_q   <= 1'b0;
      rpt_q  <= 3'b000;
    end else begin
      if (vote_en) rpt_q <= voter_rpt;
      if (do_clr) begin
        rep_q <= 1'b0;
        mm_q  <= 1'b0;
      end else begin
        if (vote_en && voter_rpt == 3'b111) rep_q <= 1'b1;
        if (mismatch) mm_q <= 1'b1;
      end
      if (do_sim) begin
        mode_q <= M_SIM;
        pick_q <= cmd_unit;
        ovr_q  <= 1'b1;
      end else if (do_dup) begin
        mode_q <= M_DUP;
        ovr_q  <= 1'b1;
      end else if (do_tri) begin
        mode_q <= M_TRI;
        ovr_q  <= 1'b1;
      end else if (do_rel) begin
        ovr_q  <= 1'b0;
      end else if (mismatch && !ovr_q) begin
        mode_q <= M_TRI;
      end
    end
  end

  assert_auto_promote_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mismatch && !status[7] && !cmd_valid) |=> (vote_en && !det_en && unit_en == 3'b111 && sel == 2'b11));

  assert_duplex_unit1_R4: assert property (@(posedge clk) disable iff (!rst_n)
    det_en |-> (sys_out == unit1_out));

  assert_simplex_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!det_en && !vote_en) |-> ($countones(unit_en) == 1));

  assert_voted_route_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'b11) |-> (sys_out == voted_word));

  assert_repair_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (vote_en && voter_rpt == 3'b111 && !(cmd_valid && cmd_op == 3'b101)) |=> status[6]);

  assert_override_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (status[7] && !cmd_valid) |=> $stable(status[1:0]));

  assert_detector_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !det_en |-> !mismatch);
endmodule

// File: tb/tb_redundancy_supervisor.sv
module tb_redundancy_supervisor;
  localparam int W = 8;
  localparam int NV = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] a = '0, b = '0, c = '0, v = '0;
  logic [2:0] rpt = '0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [1:0] cmd_unit = '0;
  logic [2:0] unit_en;
  logic det_en, vote_en, mismatch;
  logic [1:0] sel;
  logic [W-1:0] sys_out;
  logic [7:0] status;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  redundancy_supervisor #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .unit1_out(a), .unit2_out(b), .unit3_out(c),
    .voted_word(v), .voter_rpt(rpt), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_unit(cmd_unit), .unit_en(unit_en), .det_en(det_en), .vote_en(vote_en),
    .sel(sel), .sys_out(sys_out), .mismatch(mismatch), .status(status));

  // {op, unit, a, b, c, voted, rpt, exp_out, exp_status, exp_en, exp_sel}
  localparam logic [60:0] VEC [NV] = '{
    {3'd0,2'd0,8'h11,8'h11,8'h55,8'h77,3'd0,8'h11,8'h01,3'b011,2'b00}, // R4 duplex
    {3'd0,2'd0,8'h22,8'h22,8'h55,8'h77,3'd0,8'h22,8'h01,3'b011,2'b00}, // R4
    {3'd0,2'd0,8'h30,8'h31,8'h55,8'h30,3'd2,8'h30,8'h22,3'b111,2'b11}, // R3 stuck bit promotes
    {3'd0,2'd0,8'h44,8'h45,8'h44,8'h44,3'd2,8'h44,8'h2A,3'b111,2'b11}, // R7 latch
    {3'd0,2'd0,8'h44,8'h45,8'h44,8'h66,3'd7,8'h66,8'h7E,3'b111,2'b11}, // R8 set
    {3'd0,2'd0,8'h44,8'h45,8'h44,8'h67,3'd0,8'h67,8'h62,3'b111,2'b11}, // R8 sticky
    {3'd5,2'd0,8'h44,8'h45,8'h44,8'h68,3'd0,8'h68,8'h02,3'b111,2'b11}, // R11 clear
    {3'd1,2'd2,8'h44,8'h44,8'h9A,8'h68,3'd1,8'h9A,8'h84,3'b100,2'b10}, // R5 unit3
    {3'd1,2'd3,8'h44,8'h44,8'h9B,8'h68,3'd0,8'h9B,8'h84,3'b100,2'b10}, // R10 ignored
    {3'd1,2'd1,8'h44,8'h5C,8'h9B,8'h68,3'd0,8'h5C,8'h84,3'b010,2'b01}, // R6 unit2
    {3'd2,2'd0,8'h10,8'h10,8'h9B,8'h68,3'd0,8'h10,8'h85,3'b011,2'b00}, // R9 host duplex
    {3'd0,2'd0,8'h10,8'hEF,8'h9B,8'h68,3'd0,8'h10,8'hA5,3'b011,2'b00}, // R9 no promotion
    {3'd4,2'd0,8'h10,8'h10,8'h9B,8'h68,3'd0,8'h10,8'h25,3'b011,2'b00}, // R9 release
    {3'd0,2'd0,8'h10,8'h11,8'h9B,8'hAB,3'd0,8'hAB,8'h26,3'b111,2'b11}, // R3 after release
    {3'd3,2'd0,8'h10,8'h11,8'h9B,8'hAB,3'd4,8'hAB,8'hB2,3'b111,2'b11}, // R9 host triple
    {3'd1,2'd0,8'h3C,8'h11,8'h9B,8'hAB,3'd0,8'h3C,8'hA0,3'b001,2'b00}, // R5 unit1
    {3'd5,2'd0,8'h3C,8'h11,8'h9B,8'hAB,3'd0,8'h3C,8'h80,3'b001,2'b00}, // R11 clear in simplex
    {3'd2,2'd0,8'h3C,8'h3C,8'h9B,8'hAB,3'd0,8'h3C,8'h81,3'b011,2'b00}  // R9
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({29'd0, unit_en}, 32'h3, "R1 unit_en in reset");
    chk({24'd0, status}, 32'h01, "R1 status in reset");
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk({29'd0, unit_en}, 32'h3, "R1 unit_en after reset");
    chk({30'd0, det_en, vote_en}, 32'h2, "R1 det/vote enables");
    chk({30'd0, sel}, 32'h0, "R1 sel");
    chk({24'd0, status}, 32'h01, "R1 status");

    @(negedge clk);
    a = 8'h01; b = 8'h02; #1;
    chk({31'd0, mismatch}, 32'h1, "R2 duplex mismatch");
    b = 8'h01; #1;
    chk({31'd0, mismatch}, 32'h0, "R2 duplex agree");

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      cmd_op = VEC[i][60:58]; cmd_unit = VEC[i][57:56];
      cmd_valid = (VEC[i][60:58] != 3'd0);
      a = VEC[i][55:48]; b = VEC[i][47:40]; c = VEC[i][39:32];
      v = VEC[i][31:24]; rpt = VEC[i][23:21];
      @(posedge clk); #1;
      chk({24'd0, sys_out}, {24'd0, VEC[i][20:13]}, $sformatf("vector %0d sys_out", i));
      chk({24'd0, status}, {24'd0, VEC[i][12:5]}, $sformatf("vector %0d status", i));
      chk({29'd0, unit_en}, {29'd0, VEC[i][4:2]}, $sformatf("vector %0d unit_en", i));
      chk({30'd0, sel}, {30'd0, VEC[i][1:0]}, $sformatf("vector %0d sel", i));
    end

    // R2: detector gated off in triple mode
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd3; cmd_unit = 2'd0;
    @(posedge clk); #1;
    cmd_valid = 1'b0; cmd_op = 3'd0;
    a = 8'h00; b = 8'hFF; #1;
    chk({31'd0, mismatch}, 32'h0, "R2 triple gated");
    chk({30'd0, det_en, vote_en}, 32'h1, "R7 triple enables");

    // R8: clear beats a same-edge 111 report
    @(negedge clk);
    rpt = 3'b111; cmd_valid = 1'b1; cmd_op = 3'd5;
    @(posedge clk); #1;
    chk({31'd0, status[6]}, 32'h0, "R8 clear priority");
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd0;
    @(posedge clk); #1;
    chk({31'd0, status[6]}, 32'h1, "R8 set after clear");

    // R1: reset applied mid-run
    @(negedge clk);
    rst_n = 1'b0; #1;
    chk({24'd0, status}, 32'h01, "R1 mid-run reset status");
    chk({29'd0, unit_en}, 32'h3, "R1 mid-run reset unit_en");
    @(negedge clk);
    rst_n = 1'b1;

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule